// File: doc/BRIEF.md
# Predicated Element Step Skipper

This block sits beside the issue controller of a vector loop. When the controller has a source mask and a destination mask ready, it pulses `start_i` with the current source and destination element steps, the vector length, both masks and the two zeroing flags. The block captures all of them. It then moves each step forward past elements whose mask bit is clear. The source and destination sides move independently of each other, and each side moves by at most one element per clock.

A side stops moving when its current mask bit is set, when its zeroing flag is set, or when its step has reached the vector length. Each clock in which at least one step moved is followed by a one-cycle `update_o` pulse, which tells the controller to decode the vector state again. `ready_o` is high while both sides have settled. The block holds the settled steps until the next `start_i`. A new `start_i` overrides any walk that is still running.

Top module: `step_skipper`

## Requirements
- R1: After reset, `src_step_o` and `dst_step_o` are 0, and `ready_o` and `update_o` are low. `ready_o` stays low until the first `start_i`.
- R2: A clock edge with `start_i` high loads `src_step_i` and `dst_step_i` into the step outputs, which show them in the next cycle. It also captures `vl_i`, both masks and both zeroing flags.
- R3: When the source zeroing flag is clear, the source step is below VL and bit [step] of the source mask is 0, the source step rises by exactly one at the next clock edge.
- R4: The destination step follows the rule of R3 using its own mask and zeroing flag, in the same cycles as the source side and independently of it.
- R5: A side whose captured zeroing flag is 1 never moves its step, whatever its mask holds.
- R6: A step at or above the captured VL never changes, even when its mask bit reads 0. Skipping never carries a step past VL.
- R7: `update_o` is high in exactly those cycles that directly follow a clock edge at which a step advanced by skipping. A load by `start_i` does not raise it.
- R8: `ready_o` is high exactly when a walk has been started and neither side can skip in the current cycle. While it is high and `start_i` is low, both steps stay fixed and `update_o` stays low.
- R9: The mask bit tested is bit [step], for steps 0 to 63. A step of 64 or more is terminal even when it is below VL.
- R10: A `start_i` in a cycle in which a skip is pending takes priority: the new steps are loaded, no increment is applied and `update_o` stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load steps, VL, masks and flags, then begin skipping |
| src_step_i | input | 7 | Source element step to load |
| dst_step_i | input | 7 | Destination element step to load |
| vl_i | input | 7 | Vector length, the terminal step value |
| src_mask_i | input | 64 | Source predicate mask, bit n = element n active |
| dst_mask_i | input | 64 | Destination predicate mask, bit n = element n active |
| src_zero_i | input | 1 | Source zeroing requested; disables source skipping |
| dst_zero_i | input | 1 | Destination zeroing requested; disables destination skipping |
| src_step_o | output | 7 | Current source element step |
| dst_step_o | output | 7 | Current destination element step |
| update_o | output | 1 | Pulse: a step changed at the previous edge, so the vector state must be decoded again |
| ready_o | output | 1 | Both steps point at active elements or are terminal |

## Verification
Two functions can fall into the same cycle: a pending skip and a fresh load. The bench provokes the collision by starting a walk over all-zero masks and asserting `start_i` again two cycles later, while both sides still have skips pending. The load is correct if, in the following cycle, the outputs show exactly the newly loaded steps, `update_o` is low and `ready_o` reflects only the new masks. A second collision is between the two sides themselves. Vectors whose skip counts differ on each side check that `ready_o` waits for the longer side and that the `update_o` pulses match the longer count.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int NUM_LANES = 2;
  localparam int LANE_SRC  = 0;
  localparam int LANE_DST  = 1;
endpackage

// File: rtl/skip_lane.sv
module skip_lane #(
  parameter int STEP_W = 7,
  parameter int MASK_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [STEP_W-1:0] load_step_i,
  input  logic              active_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              zero_i,
  input  logic [STEP_W-1:0] vl_i,
  output logic [STEP_W-1:0] step_o,
  output logic              skip_o
);
  localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;
  localparam logic [STEP_W-1:0] MASK_LIM = STEP_W'(MASK_W);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_inc;
  logic [IDX_W-1:0]  bit_idx;
  logic              in_mask;
  logic              below_vl;
  logic              bit_set;

  // next value precomputed ahead of the decision
  assign step_inc = step_q + STEP_W'(1);
  assign bit_idx  = IDX_W'(step_q);
  assign in_mask  = step_q < MASK_LIM;
  assign below_vl = step_q < vl_i;
  assign bit_set  = mask_i[bit_idx];
  assign skip_o   = active_i && !zero_i && below_vl && in_mask && !bit_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      step_q <= '0;
    else if (load_i)  step_q <= load_step_i;
    else if (skip_o)  step_q <= step_inc;
  end

  assign step_o = step_q;
endmodule

// File: rtl/step_skipper.sv
module step_skipper
  import skip_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int MASK_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] src_step_i,
  input  logic [STEP_W-1:0] dst_step_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic [MASK_W-1:0] src_mask_i,
  input  logic [MASK_W-1:0] dst_mask_i,
  input  logic              src_zero_i,
  input  logic              dst_zero_i,
  output logic [STEP_W-1:0] src_step_o,
  output logic [STEP_W-1:0] dst_step_o,
  output logic              update_o,
  output logic              ready_o
);
  logic [STEP_W-1:0]    load_step [NUM_LANES];
  logic [MASK_W-1:0]    mask_in   [NUM_LANES];
  logic [NUM_LANES-1:0] zero_in;
  logic [MASK_W-1:0]    mask_q    [NUM_LANES];
  logic [NUM_LANES-1:0] zero_q;
  logic [STEP_W-1:0]    vl_q;
  logic                 active_q;
  logic                 update_q;
  logic [STEP_W-1:0]    step_cur  [NUM_LANES];
  logic [NUM_LANES-1:0] skip;

  assign load_step[LANE_SRC] = src_step_i;
  assign load_step[LANE_DST] = dst_step_i;
  assign mask_in[LANE_SRC]   = src_mask_i;
  assign mask_in[LANE_DST]   = dst_mask_i;
  assign zero_in[LANE_SRC]   = src_zero_i;
  assign zero_in[LANE_DST]   = dst_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q     <= '0;
      zero_q   <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      vl_q     <= vl_i;
      zero_q   <= zero_in;
      active_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mask_q[g] <= '0;
      else if (start_i) mask_q[g] <= mask_in[g];
    end

    skip_lane #(.STEP_W(STEP_W), .MASK_W(MASK_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (start_i),
      .load_step_i(load_step[g]),
      .active_i   (active_q),
      .mask_i     (mask_q[g]),
      .zero_i     (zero_q[g]),
      .vl_i       (vl_q),
      .step_o     (step_cur[g]),
      .skip_o     (skip[g])
    );
  end

  // load wins over a pending skip, so no pulse follows a restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) update_q <= 1'b0;
    else         update_q <= |skip && !start_i;
  end

  assign src_step_o = step_cur[LANE_SRC];
  assign dst_step_o = step_cur[LANE_DST];
  assign update_o   = update_q;
  assign ready_o    = active_q && !(|skip);
endmodule

// File: rtl/step_skipper_chk.sv
module step_skipper_chk #(
  parameter int STEP_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              active_i,
  input logic [STEP_W-1:0] vl_i,
  input logic [1:0]        zero_i,
  input logic [STEP_W-1:0] src_step_i,
  input logic [STEP_W-1:0] dst_step_i,
  input logic              update_i,
  input logic              ready_i
);
  p_src_unit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (src_step_i == $past(src_step_i)) ||
                 (src_step_i == $past(src_step_i) + STEP_W'(1)));

  p_dst_unit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (dst_step_i == $past(dst_step_i)) ||
                 (dst_step_i == $past(dst_step_i) + STEP_W'(1)));

  p_zero_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !start_i && zero_i[0] |=> $stable(src_step_i));

  p_zero_hold_dst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && !start_i && zero_i[1] |=> $stable(dst_step_i));

  p_no_pass_vl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && (src_step_i >= vl_i) && (dst_step_i >= vl_i)
    |=> $stable(src_step_i) && $stable(dst_step_i));

  p_update_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> update_i == ((src_step_i != $past(src_step_i)) ||
                              (dst_step_i != $past(dst_step_i))));

  p_ready_settled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && !start_i |=> $stable(src_step_i) && $stable(dst_step_i) &&
                            !update_i && ready_i);

  p_idle_not_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !ready_i && !update_i);

  p_restart_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !update_i);
endmodule

bind step_skipper step_skipper_chk #(.STEP_W(STEP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .active_i  (active_q),
  .vl_i      (vl_q),
  .zero_i    (zero_q),
  .src_step_i(src_step_o),
  .dst_step_i(dst_step_o),
  .update_i  (update_o),
  .ready_i   (ready_o)
);

// File: tb/step_skipper_test.sv
`timescale 1ns/1ps
module step_skipper_test;
  typedef struct packed {
    logic [6:0]  src;
    logic [6:0]  dst;
    logic [6:0]  vl;
    logic [63:0] smask;
    logic [63:0] dmask;
    logic        sz;
    logic        dz;
    logic [6:0]  exp_src;
    logic [6:0]  exp_dst;
    logic [7:0]  exp_cyc;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{7'd0,  7'd0,  7'd8,   64'hF0, 64'h4, 1'b0, 1'b0, 7'd4,  7'd2,  8'd4},
    '{7'd3,  7'd5,  7'd10,  '1,     '1,    1'b0, 1'b0, 7'd3,  7'd5,  8'd0},
    '{7'd0,  7'd1,  7'd16,  64'h0,  64'h8, 1'b1, 1'b0, 7'd0,  7'd3,  8'd2},
    '{7'd0,  7'd2,  7'd5,   64'h0,  64'h0, 1'b0, 1'b0, 7'd5,  7'd5,  8'd5},
    '{7'd6,  7'd6,  7'd6,   64'h0,  64'h0, 1'b0, 1'b0, 7'd6,  7'd6,  8'd0},
    '{7'd9,  7'd2,  7'd6,   64'h0,  64'h0, 1'b0, 1'b0, 7'd9,  7'd6,  8'd4},
    '{7'd1,  7'd0,  7'd12,  64'h8,  64'h0, 1'b0, 1'b1, 7'd3,  7'd0,  8'd2},
    '{7'd60, 7'd62, 7'd64,  64'h8000_0000_0000_0000, 64'h0, 1'b0, 1'b0, 7'd63, 7'd64, 8'd3},
    '{7'd64, 7'd61, 7'd100, 64'h0,  64'h0, 1'b0, 1'b0, 7'd64, 7'd64, 8'd3},
    '{7'd7,  7'd20, 7'd30,  64'h0,  64'h0, 1'b1, 1'b1, 7'd7,  7'd20, 8'd0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  src_step_i = '0;
  logic [6:0]  dst_step_i = '0;
  logic [6:0]  vl_i = '0;
  logic [63:0] src_mask_i = '0;
  logic [63:0] dst_mask_i = '0;
  logic        src_zero_i = 1'b0;
  logic        dst_zero_i = 1'b0;
  logic [6:0]  src_step_o;
  logic [6:0]  dst_step_o;
  logic        update_o;
  logic        ready_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk_i = ~clk_i;

  step_skipper uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .src_step_i(src_step_i), .dst_step_i(dst_step_i), .vl_i(vl_i),
    .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
    .src_zero_i(src_zero_i), .dst_zero_i(dst_zero_i),
    .src_step_o(src_step_o), .dst_step_o(dst_step_o),
    .update_o(update_o), .ready_o(ready_o)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(int i);
    case (i)
      0: return "R3";
      1: return "R8";
      2: return "R5";
      3: return "R4";
      4: return "R6";
      5: return "R6";
      6: return "R5";
      7: return "R9";
      8: return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic load(vec_t v);
    @(negedge clk_i);
    start_i = 1'b1;
    src_step_i = v.src; dst_step_i = v.dst; vl_i = v.vl;
    src_mask_i = v.smask; dst_mask_i = v.dmask;
    src_zero_i = v.sz; dst_zero_i = v.dz;
    @(negedge clk_i);
    start_i = 1'b0;
    src_mask_i = '0; dst_mask_i = '0; src_zero_i = 1'b0; dst_zero_i = 1'b0;
  endtask

  task automatic run_vec(int i);
    vec_t v = VECS[i];
    int cyc = 0;
    int upd = 0;
    load(v);
    chk("R2", "loaded src", src_step_o, v.src);
    chk("R2", "loaded dst", dst_step_o, v.dst);
    chk("R7", "update after load", update_o, 0);
    while (!ready_o && cyc < 200) begin
      @(negedge clk_i);
      cyc++;
      if (update_o) upd++;
    end
    chk(tag_of(i), "final src", src_step_o, v.exp_src);
    chk(tag_of(i), "final dst", dst_step_o, v.exp_dst);
    chk("R8", "cycles to ready", cyc, v.exp_cyc);
    chk("R7", "update pulses", upd, v.exp_cyc);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "reset src", src_step_o, 0);
    chk("R1", "reset dst", dst_step_o, 0);
    chk("R1", "reset ready", ready_o, 0);
    chk("R1", "reset update", update_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1", "idle ready", ready_o, 0);

    for (int i = 0; i < NVEC; i++) run_vec(i);

    // R8: settled state holds with masks driven differently
    repeat (3) @(negedge clk_i);
    chk("R8", "hold src", src_step_o, 7);
    chk("R8", "hold dst", dst_step_o, 20);
    chk("R8", "hold update", update_o, 0);
    chk("R8", "hold ready", ready_o, 1);

    // R10: restart while skips are pending
    load(VECS[3]);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10", "mid src", src_step_o, 2);
    chk("R10", "mid dst", dst_step_o, 4);
    start_i = 1'b1;
    src_step_i = 7'd10; dst_step_i = 7'd11; vl_i = 7'd20;
    src_mask_i = '1; dst_mask_i = '1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10", "restart src", src_step_o, 10);
    chk("R10", "restart dst", dst_step_o, 11);
    chk("R10", "restart update", update_o, 0);
    chk("R10", "restart ready", ready_o, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule